// File: doc/BRIEF.md
# Processor Tick Timer

This block is the tick timer of a processor core. It has a full-width count register and a control register. Both are reached through a single-word register port with a one-bit register select. The control register holds a compare period, an interrupt enable, a sticky interrupt pending flag and a two-bit action mode. A tick strobe, made by a divider outside the block (nominally one strobe every 50 ns), advances the count by one while the timer runs.

Each advancing tick compares the low period-wide bits of the incremented count against the programmed period. The upper count bits take no part in this compare. When the two are equal, the timer records a match. A match sets the pending flag if interrupts are enabled. It then restarts the count from zero, halts the count, or lets it run on, depending on the mode. If the period is at or below the current low bits, the next match comes only after those bits wrap through their maximum. The interrupt output is the pending flag gated by the enable.

Top module: `tick_timer`

## Requirements
- R1: After reset the count reads 0, the control register reads 0 and `irq_o` is 0.
- R2: The count rises by exactly one on each cycle with `tick_i` high while the mode is not 00 and the timer is not halted. With mode 00 (off), ticks leave the count unchanged and produce no match.
- R3: A match happens on an advancing tick when the low PER_W bits of the count plus one equal the period field (control bits [PER_W-1:0]). Count bits at PER_W and above do not affect the compare.
- R4: Let the low bits be c and the period be p after a write. If p > c, the first match is on tick p-c. Otherwise it is on tick 2^PER_W - c + p, so p == c waits a full wrap.
- R5: A match with the enable bit (control bit 29) at 1 sets the pending bit (control bit 28). `irq_o` equals pending AND enable. A match with the enable bit at 0 leaves the pending bit at 0.
- R6: The pending bit is sticky. A control write with bit 28 at 0 clears it. A control write with bit 28 at 1 keeps its current value and never sets it.
- R7: Mode 01 (restart): the count becomes 0 on the matching tick.
- R8: Mode 10 (one-shot): the count takes the matching value and then holds through later ticks. Any control write re-arms counting.
- R9: Mode 11 (continuous): the count keeps rising by one through the match.
- R10: A count write (select 0) loads the write data and reads back at once. It takes priority over a tick in the same cycle, and that tick neither advances the count nor matches.
- R11: The control register reads back its mode (bits [31:30]), enable, pending and period fields. Bits between the period field and bit 28 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-cycle timer tick strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 count, 1 control |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Read data of the selected register (combinational) |
| irq_o | output | 1 | Timer interrupt request |

## Verification
The hardest case to reach from the ports is the wrap-around match, where the period is at or below the current low count bits. With a full-width period field, that match lies hundreds of millions of ticks away. The bench therefore builds the block with a six-bit period field. It then sweeps pairs of starting low bits and periods, including equal values, zero and the field maximum, in every acting mode. For each pair it computes the tick distance arithmetically and checks that the interrupt is still quiet one tick before the match and raised on the match tick. Starting counts with set upper bits, including values near the 32-bit limit, show that the upper bits are ignored.

// File: rtl/tick_timer_pkg.sv
// Shared types for the tick timer.
// Assumes: the mode field is two bits wide and sits at the top of the control word.
package tick_timer_pkg;

    // Action taken when a match occurs
    typedef enum logic [1:0] {
        TMODE_OFF      = 2'b00,
        TMODE_RESTART  = 2'b01,
        TMODE_ONESHOT  = 2'b10,
        TMODE_FREE     = 2'b11
    } tmode_e;

endpackage

// File: rtl/tick_timer_counter.sv
// Full-width count register.
// Does: loads software data, clears on a restart match, otherwise steps by one on advance.
// Assumes: load has priority; adv is already masked against load by the parent.
module tick_timer_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             clr_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count register update: load, then clear, then step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

    assert_load_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == $past(load_val_i));
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clr_i && !adv_i) |=> $stable(cnt_q));
    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clr_i && adv_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

endmodule

// File: rtl/tick_timer_match.sv
// Period compare.
// Does: flags a match when the masked low count bits, after this tick's increment, equal the period.
// Assumes: only the low PER_W bits of the count are given; upper bits never take part.
module tick_timer_match #(
    parameter int PER_W = 28
) (
    input  logic [PER_W-1:0] cnt_low_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             adv_i,
    output logic             hit_o
);

    logic [PER_W-1:0] next_low;

    // Incremented low bits wrap naturally within the field
    always_comb begin
        next_low = cnt_low_i + PER_W'(1);
        hit_o    = adv_i && (next_low == period_i);
    end

endmodule

// File: rtl/tick_timer_ctrl.sv
// Control register and run state.
// Does: holds mode, enable, sticky pending and period; halts after a one-shot match;
//       derives the run enable and the restart clear.
// Assumes: hit_i was computed with the register values of the current cycle.
module tick_timer_ctrl
    import tick_timer_pkg::*;
#(
    parameter int PER_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  tmode_e           mode_w_i,
    input  logic             ie_w_i,
    input  logic             ip_w_i,
    input  logic [PER_W-1:0] per_w_i,
    input  logic             hit_i,
    output tmode_e           mode_o,
    output logic             ie_o,
    output logic             ip_o,
    output logic [PER_W-1:0] period_o,
    output logic             run_o,
    output logic             halted_o,
    output logic             restart_o
);

    tmode_e           mode_q;
    logic             ie_q;
    logic             ip_q;
    logic             halted_q;
    logic [PER_W-1:0] period_q;

    // Configuration fields and one-shot halt flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= TMODE_OFF;
            ie_q     <= 1'b0;
            period_q <= '0;
            halted_q <= 1'b0;
        end else if (wr_i) begin
            mode_q   <= mode_w_i;
            ie_q     <= ie_w_i;
            period_q <= per_w_i;
            halted_q <= 1'b0;
        end else if (hit_i && mode_q == TMODE_ONESHOT) begin
            halted_q <= 1'b1;
        end
    end

    // Sticky pending: set by an enabled match, cleared only by writing zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q <= 1'b0;
        end else begin
            ip_q <= (hit_i && ie_q) || (ip_q && !(wr_i && !ip_w_i));
        end
    end

    // Derived controls for the counter
    always_comb begin
        run_o     = (mode_q != TMODE_OFF) && !halted_q;
        restart_o = hit_i && (mode_q == TMODE_RESTART);
    end

    assign mode_o   = mode_q;
    assign ie_o     = ie_q;
    assign ip_o     = ip_q;
    assign period_o = period_q;
    assign halted_o = halted_q;

    assert_pending_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ip_q) |-> $past(hit_i && ie_q));
    assert_pending_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !ip_w_i && !hit_i) |=> !ip_q);
    assert_pending_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_q && !(wr_i && !ip_w_i)) |=> ip_q);

endmodule

// File: rtl/tick_timer.sv
// Tick timer top.
// Does: register port for count (select 0) and control (select 1), period match,
//       mode actions and interrupt output.
// Assumes: tick_i is a single-cycle strobe at the timer rate; PER_W <= CNT_W-4.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PER_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             reg_we_i,
    input  logic             reg_sel_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] reg_rdata_o,
    output logic             irq_o
);

    localparam int MODE_LSB = CNT_W - 2;
    localparam int IE_BIT   = CNT_W - 3;
    localparam int IP_BIT   = CNT_W - 4;
    localparam int GAP_W    = IP_BIT - PER_W;

    logic             cnt_wr, ctl_wr, adv, hit, run, halted, restart;
    logic             ie, ip;
    tmode_e           mode;
    logic [PER_W-1:0] period;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ctl_word;

    // Write decode and tick qualification (count write suppresses the tick)
    always_comb begin
        cnt_wr = reg_we_i && !reg_sel_i;
        ctl_wr = reg_we_i && reg_sel_i;
        adv    = tick_i && run && !cnt_wr;
    end

    tick_timer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_wr),
        .load_val_i (reg_wdata_i),
        .clr_i      (restart),
        .adv_i      (adv),
        .cnt_o      (cnt)
    );

    tick_timer_match #(.PER_W(PER_W)) u_match (
        .cnt_low_i (cnt[PER_W-1:0]),
        .period_i  (period),
        .adv_i     (adv),
        .hit_o     (hit)
    );

    tick_timer_ctrl #(.PER_W(PER_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (ctl_wr),
        .mode_w_i  (tmode_e'(reg_wdata_i[CNT_W-1:MODE_LSB])),
        .ie_w_i    (reg_wdata_i[IE_BIT]),
        .ip_w_i    (reg_wdata_i[IP_BIT]),
        .per_w_i   (reg_wdata_i[PER_W-1:0]),
        .hit_i     (hit),
        .mode_o    (mode),
        .ie_o      (ie),
        .ip_o      (ip),
        .period_o  (period),
        .run_o     (run),
        .halted_o  (halted),
        .restart_o (restart)
    );

    // Control word assembly: unused gap reads zero when present
    generate
        if (GAP_W > 0) begin : g_gap
            logic unused_gap_bits;
            assign unused_gap_bits = ^reg_wdata_i[IP_BIT-1:PER_W];
            assign ctl_word = {mode, ie, ip, {GAP_W{1'b0}}, period};
        end else begin : g_nogap
            assign ctl_word = {mode, ie, ip, period};
        end
    endgenerate

    // Read mux and interrupt gate
    always_comb begin
        reg_rdata_o = reg_sel_i ? ctl_word : cnt;
        irq_o       = ip && ie;
    end

    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == TMODE_RESTART && !cnt_wr) |=> cnt == '0);
    assert_oneshot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !reg_we_i) |=> $stable(cnt));
    assert_free_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == TMODE_FREE) |=> cnt == $past(cnt) + CNT_W'(1));
    assert_off_no_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TMODE_OFF) |-> !hit);

endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;

    localparam int PW = 6;
    localparam int FULL = 1 << PW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tick_timer #(.CNT_W(32), .PER_W(PW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .reg_we_i    (reg_we),
        .reg_sel_i   (reg_sel),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    function automatic logic [31:0] mk(input logic [1:0] m, input logic ie,
                                       input logic ip, input int per);
        return {m, ie, ip, 22'b0, 6'(per)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d, input logic tk);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d; tick = tk;
        @(posedge clk); #1;
        reg_we = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(posedge clk); #1; tick = 1'b0;
        end
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel; #1; v = reg_rdata;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v, start, exp;
        int wait_t, k, cur, per;
        int curs[6] = '{0, 1, 17, 31, 62, 63};
        int pers[6] = '{0, 1, 17, 31, 62, 63};
        logic [1:0] modes[3] = '{2'b01, 2'b10, 2'b11};

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(0, v); chk("R1 count", v, 0);
        rd(1, v); chk("R1 ctrl", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 mode off: ticks do nothing, no match even at period
        wr(0, 32'h0000_0004, 0);
        wr(1, mk(2'b00, 1, 0, 5), 0);
        ticks(70);
        rd(0, v); chk("R2 off holds", v, 32'h4);
        rd(1, v); chk("R2 off no pending", v, mk(2'b00, 1, 0, 5));

        // R3 R4 R5 R7 R8 R9 sweep: mode x start low bits x period
        foreach (modes[mi]) foreach (curs[ci]) foreach (pers[pi]) begin
            cur = curs[ci]; per = pers[pi];
            start = ((ci % 2) == 0) ? (32'hFFFF_FFC0 | 32'(cur)) : (32'h5A3C_8040 | 32'(cur));
            wait_t = (per > cur) ? (per - cur) : (FULL - cur + per);
            wr(0, start, 0);
            wr(1, mk(modes[mi], 1, 0, per), 0);
            ticks(wait_t - 1);
            chk("R4 no early irq", {31'b0, irq}, 0);
            rd(0, v); chk("R2 steps before match", v, start + 32'(wait_t - 1));
            ticks(1);
            chk("R5 irq at match", {31'b0, irq}, 1);
            rd(1, v); chk("R5 pending bit", v, mk(modes[mi], 1, 1, per));
            rd(0, v);
            exp = (modes[mi] == 2'b01) ? 32'h0 : start + 32'(wait_t);
            chk(modes[mi] == 2'b01 ? "R7 cleared" : (modes[mi] == 2'b10 ? "R8 stop value" : "R9 run through"), v, exp);
            ticks(3);
            rd(0, v);
            if (modes[mi] == 2'b01) begin
                k = (per >= 1 && per <= 3) ? (3 % per) : 3;
                chk("R7 restart from zero", v, 32'(k));
            end else if (modes[mi] == 2'b10) begin
                chk("R8 holds", v, start + 32'(wait_t));
            end else begin
                chk("R9 keeps counting", v, start + 32'(wait_t + 3));
            end
        end

        // R8 rearm by a control write after one-shot halt
        wr(0, 32'h0000_0010, 0);
        wr(1, mk(2'b10, 1, 0, 20), 0);
        ticks(6);
        rd(0, v); chk("R8 halted", v, 32'h14);
        wr(1, mk(2'b10, 1, 0, 30), 0);
        ticks(2);
        rd(0, v); chk("R8 rearmed", v, 32'h16);

        // R5 enable off: match leaves pending clear
        wr(0, 32'h0000_0000, 0);
        wr(1, mk(2'b11, 0, 0, 3), 0);
        ticks(3);
        chk("R5 no irq with ie=0", {31'b0, irq}, 0);
        rd(1, v); chk("R5 no pending with ie=0", v, mk(2'b11, 0, 0, 3));

        // R6 sticky pending
        wr(1, mk(2'b11, 1, 0, 8), 0);
        ticks(5);
        chk("R6 pending set", {31'b0, irq}, 1);
        wr(1, mk(2'b11, 1, 1, 60), 0);
        ticks(4);
        rd(1, v); chk("R6 write one keeps", v, mk(2'b11, 1, 1, 60));
        wr(1, mk(2'b11, 0, 1, 60), 0);
        chk("R5 irq gated by ie", {31'b0, irq}, 0);
        wr(1, mk(2'b11, 1, 1, 60), 0);
        chk("R5 irq returns with ie", {31'b0, irq}, 1);
        wr(1, mk(2'b11, 1, 0, 60), 0);
        rd(1, v); chk("R6 write zero clears", v, mk(2'b11, 1, 0, 60));
        wr(1, mk(2'b11, 1, 1, 60), 0);
        rd(1, v); chk("R6 write one never sets", v, mk(2'b11, 1, 0, 60));

        // R10 count write beats a same-cycle tick, no match from that tick
        wr(1, mk(2'b11, 1, 0, 8), 0);
        wr(0, 32'h1234_5607, 1);
        rd(0, v); chk("R10 write wins", v, 32'h1234_5607);
        chk("R10 no match on write tick", {31'b0, irq}, 0);
        ticks(1);
        chk("R3 match upper ignored", {31'b0, irq}, 1);

        // R11 gap bits read zero
        wr(1, 32'h0FFF_FFFF, 0);
        rd(1, v); chk("R11 gap zero", v, 32'h0000_003F);

        finish_run();
    end

endmodule